// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the SCL waveform for an I2C controller from the system clock. It drives SCL through an open-drain enable: a high `scl_oe_o` pulls the line low, and a low `scl_oe_o` releases it. It runs in standard mode (up to 100 kHz) or in fast mode (up to 400 kHz). Fast mode has two low/high duty ratios. A divider field sets every phase length in system-clock cycles. Each mode has its own lower limit on that divider.

After each low phase the block releases SCL. It then waits for two conditions before it counts the high phase: a programmed rise-time allowance must have run out, and the sampled SCL must read high. A device that holds SCL low therefore stretches the clock. One-cycle strobes mark the first cycle of each low phase and of each high phase, so the surrounding controller can step its data and START/STOP logic. The divider, mode, duty and rise fields are captured at the start of each low phase and stay fixed for that whole SCL period.

Top module: `scl_timing_gen`

## Requirements
- R1: In standard mode (`fast_i`=0) with divider c ≥ 4, SCL is driven low for c cycles, and the high phase lasts c cycles.
- R2: In fast mode (`fast_i`=1) with `duty_i`=0 and divider c ≥ 1, the low phase is 2c cycles and the high phase is c cycles.
- R3: In fast mode with `duty_i`=1 and divider c ≥ 1, the low phase is 16c cycles and the high phase is 9c cycles.
- R4: In standard mode a divider value of 0, 1, 2 or 3 behaves as 4.
- R5: In fast mode a divider value of 0 behaves as 1, for either duty setting.
- R6: After SCL is released with the sampled SCL already high, the high-phase strobe appears max(r,1) cycles later, where r is the rise field. Those cycles are the wait.
- R7: While the sampled SCL reads low after release, the high phase does not begin. It begins in the cycle after the first cycle in which SCL reads high and the rise allowance has run out.
- R8: While reset is high or `en_i` is low, `scl_oe_o`, `low_start_o` and `high_start_o` are 0 from the next cycle onward. The cycle after `en_i` is sampled high starts a low phase.
- R9: `low_start_o` is high exactly in the first cycle of each low phase, which is the cycle in which `scl_oe_o` rises. `high_start_o` is high only in the first high-phase cycle, with SCL released.
- R10: Changes to the divider, mode, duty or rise fields affect only SCL periods whose low phase starts after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Generator enable |
| fast_i | input | 1 | 1 selects fast mode, 0 selects standard mode |
| duty_i | input | 1 | Fast-mode duty: 0 is ratio 2, 1 is ratio 16/9 |
| clkc_i | input | DIV_W | Phase divider c |
| rise_i | input | RISE_W | Rise-time allowance in cycles (maximum rise time plus one) |
| scl_in_i | input | 1 | SCL line level, already sampled into the clock domain |
| scl_oe_o | output | 1 | 1 drives SCL low, 0 releases it |
| low_start_o | output | 1 | Strobe in the first cycle of a low phase |
| high_start_o | output | 1 | Strobe in the first cycle of a high phase |

## Verification
The bench uses the default widths: a 12-bit divider and a 6-bit rise field. It drives only small divider values, so even the 25c period of the 16/9 duty stays short. Those widths still allow every clamp value (0 to 3 in standard mode, 0 in fast mode) and both duty multipliers to be reached. The rise field reaches both 0 and values above 1, so the bench can tell the one-cycle wait floor apart from a real allowance. A bench-driven hold on the wired-AND SCL model checks stretching well beyond the rise allowance.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } scl_state_e;

  // extra length bits needed above the divider width (16x multiplier plus margin)
  localparam int unsigned LEN_EXTRA = 5;
  localparam int unsigned STD_MIN_DIV = 4;
endpackage

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
  import scl_gen_pkg::*;
#(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned LEN_W = DIV_W + LEN_EXTRA
) (
  input  logic             fast_i,
  input  logic             duty_i,
  input  logic [DIV_W-1:0] clkc_i,
  output logic [LEN_W-1:0] low_len_o,
  output logic [LEN_W-1:0] high_len_o
);
  localparam logic [DIV_W-1:0] STD_FLOOR  = DIV_W'(STD_MIN_DIV);
  localparam logic [DIV_W-1:0] FAST_FLOOR = DIV_W'(1);

  logic [DIV_W-1:0] div_eff;
  logic [LEN_W-1:0] c_ext;

  // clamp the divider to the floor of the selected mode
  always_comb begin
    if (fast_i) begin
      div_eff = (clkc_i == '0) ? FAST_FLOOR : clkc_i;
    end else begin
      div_eff = (clkc_i < STD_FLOOR) ? STD_FLOOR : clkc_i;
    end
  end

  assign c_ext = LEN_W'(div_eff);

  always_comb begin
    if (!fast_i) begin
      low_len_o  = c_ext;
      high_len_o = c_ext;
    end else if (!duty_i) begin
      low_len_o  = c_ext << 1;
      high_len_o = c_ext;
    end else begin
      low_len_o  = c_ext << 4;
      high_len_o = (c_ext << 3) + c_ext;
    end
  end
endmodule

// File: rtl/scl_down_counter.sv
module scl_down_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int unsigned DIV_W  = 12,
  parameter int unsigned RISE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              fast_i,
  input  logic              duty_i,
  input  logic [DIV_W-1:0]  clkc_i,
  input  logic [RISE_W-1:0] rise_i,
  input  logic              scl_in_i,
  output logic              scl_oe_o,
  output logic              low_start_o,
  output logic              high_start_o
);
  localparam int unsigned   LEN_W    = DIV_W + LEN_EXTRA;
  localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
  localparam logic [RISE_W-1:0] RISE_ONE = RISE_W'(1);

  scl_state_e        st_q;
  logic [LEN_W-1:0]  low_len_c, high_len_c;
  logic [LEN_W-1:0]  hi_len_q;
  logic [RISE_W-1:0] rise_q;

  logic go_low, leave_low, leave_wait;
  logic ph_load, ph_zero, rs_load, rs_zero;
  logic [LEN_W-1:0]  ph_val;
  logic [RISE_W-1:0] rs_val;

  scl_phase_calc #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_calc (
    .fast_i    (fast_i),
    .duty_i    (duty_i),
    .clkc_i    (clkc_i),
    .low_len_o (low_len_c),
    .high_len_o(high_len_c)
  );

  // a new period (and a new config snapshot) starts only here
  assign go_low     = en_i && ((st_q == ST_OFF) || ((st_q == ST_HIGH) && ph_zero));
  assign leave_low  = en_i && (st_q == ST_LOW) && ph_zero;
  assign leave_wait = en_i && (st_q == ST_WAIT) && rs_zero && scl_in_i;

  assign ph_load = go_low || leave_wait;
  assign ph_val  = go_low ? (low_len_c - LEN_ONE) : (hi_len_q - LEN_ONE);
  assign rs_load = leave_low;
  assign rs_val  = (rise_q == '0) ? '0 : (rise_q - RISE_ONE);

  scl_down_counter #(.W(LEN_W)) u_phase_cnt (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (!en_i),
    .load_i    (ph_load),
    .load_val_i(ph_val),
    .zero_o    (ph_zero)
  );

  scl_down_counter #(.W(RISE_W)) u_rise_cnt (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (!en_i),
    .load_i    (rs_load),
    .load_val_i(rs_val),
    .zero_o    (rs_zero)
  );

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      st_q         <= ST_OFF;
      scl_oe_o     <= 1'b0;
      low_start_o  <= 1'b0;
      high_start_o <= 1'b0;
      hi_len_q     <= '0;
      rise_q       <= '0;
    end else begin
      low_start_o  <= 1'b0;
      high_start_o <= 1'b0;
      if (go_low) begin
        st_q        <= ST_LOW;
        scl_oe_o    <= 1'b1;
        low_start_o <= 1'b1;
        hi_len_q    <= high_len_c;
        rise_q      <= rise_i;
      end else if (leave_low) begin
        st_q     <= ST_WAIT;
        scl_oe_o <= 1'b0;
      end else if (leave_wait) begin
        st_q         <= ST_HIGH;
        high_start_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic scl_in_i,
  input logic scl_oe_o,
  input logic low_start_o,
  input logic high_start_o
);
  // R8: a low enable silences every output from the next cycle
  a_r8_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!scl_oe_o && !low_start_o && !high_start_o));

  // R9: the low strobe coincides exactly with SCL being pulled low
  a_r9_low_strobe_on_rise: assert property (@(posedge clk) disable iff (rst)
    low_start_o == $rose(scl_oe_o));

  // R9: the high strobe only occurs with SCL released
  a_r9_high_strobe_released: assert property (@(posedge clk) disable iff (rst)
    high_start_o |-> !scl_oe_o);

  // R9: the two strobes never overlap
  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(low_start_o && high_start_o));

  // R7: the high phase begins only after SCL was seen high
  a_r7_high_after_line_high: assert property (@(posedge clk) disable iff (rst)
    high_start_o |-> $past(scl_in_i));

  // R6: at least one released cycle precedes the high phase
  a_r6_wait_before_high: assert property (@(posedge clk) disable iff (rst)
    high_start_o |-> !$past(scl_oe_o));
endmodule

bind scl_timing_gen scl_timing_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .en_i        (en_i),
  .scl_in_i    (scl_in_i),
  .scl_oe_o    (scl_oe_o),
  .low_start_o (low_start_o),
  .high_start_o(high_start_o)
);

// File: tb/scl_timing_gen_tb.sv
`timescale 1ns/1ps
module scl_timing_gen_tb;
  localparam int unsigned DIV_W  = 12;
  localparam int unsigned RISE_W = 6;
  localparam int NVEC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, fast = 1'b0, duty = 1'b0, stretch = 1'b0;
  logic [DIV_W-1:0]  clkc = '0;
  logic [RISE_W-1:0] rise = '0;
  logic scl_oe, low_start, high_start, scl_line;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  // wired-AND bus: pulled high unless the DUT or a stretching device holds it
  assign scl_line = ~scl_oe & ~stretch;

  scl_timing_gen #(.DIV_W(DIV_W), .RISE_W(RISE_W)) u_dut (
    .clk(clk), .rst(rst), .en_i(en), .fast_i(fast), .duty_i(duty),
    .clkc_i(clkc), .rise_i(rise), .scl_in_i(scl_line),
    .scl_oe_o(scl_oe), .low_start_o(low_start), .high_start_o(high_start)
  );

  // fields: fast, duty, clkc[12], rise[6], low[16], high[16], wait[8]
  localparam logic [59:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 12'd5, 6'd3, 16'd5,  16'd5,  8'd3},
    {1'b0, 1'b0, 12'd2, 6'd0, 16'd4,  16'd4,  8'd1},
    {1'b0, 1'b0, 12'd0, 6'd1, 16'd4,  16'd4,  8'd1},
    {1'b1, 1'b0, 12'd3, 6'd2, 16'd6,  16'd3,  8'd2},
    {1'b1, 1'b0, 12'd0, 6'd0, 16'd2,  16'd1,  8'd1},
    {1'b1, 1'b1, 12'd2, 6'd4, 16'd32, 16'd18, 8'd4},
    {1'b1, 1'b1, 12'd0, 6'd1, 16'd16, 16'd9,  8'd1},
    {1'b0, 1'b0, 12'd7, 6'd9, 16'd7,  16'd7,  8'd9}
  };

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // entry: at a negedge in the first cycle of a low phase
  task automatic measure(input int hold, output int l, output int w, output int h);
    check("R9 low strobe at low start", int'(low_start), 1);
    l = 0;
    while (scl_oe) begin l++; @(negedge clk); end
    w = 0;
    while (!high_start) begin
      w++;
      if (w == hold) stretch = 1'b0;
      @(negedge clk);
    end
    h = 0;
    while (!scl_oe) begin h++; @(negedge clk); end
  endtask

  task automatic restart();
    en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check("R8 low phase one cycle after enable", int'(scl_oe), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int l, w, h;
    // R8: reset state, enable requested during reset
    en = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset scl_oe", int'(scl_oe), 0);
    check("R8 reset strobes", int'(low_start | high_start), 0);
    @(negedge clk);
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      en = 1'b0;
      fast = VEC[i][59];
      duty = VEC[i][58];
      clkc = VEC[i][57:46];
      rise = VEC[i][45:40];
      restart();
      measure(0, l, w, h);
      check($sformatf("R1 R2 R3 R4 R5 low length vec %0d", i), l, int'(VEC[i][39:24]));
      check($sformatf("R1 R2 R3 R4 R5 high length vec %0d", i), h, int'(VEC[i][23:8]));
      check($sformatf("R6 wait length vec %0d", i), w, int'(VEC[i][7:0]));
      measure(0, l, w, h);
      check($sformatf("R1 R2 R3 second period low vec %0d", i), l, int'(VEC[i][39:24]));
    end

    // R7: a device stretches SCL for 10 released cycles, rise allowance 2
    fast = 1'b0; duty = 1'b0; clkc = 12'd5; rise = 6'd2;
    restart();
    stretch = 1'b1;
    measure(10, l, w, h);
    check("R7 stretched wait", w, 10);
    check("R7 high length after stretch", h, 5);
    check("R7 low length before stretch", l, 5);

    // R10: config change inside a low phase applies to the next period only
    clkc = 12'd5; rise = 6'd1;
    restart();
    clkc = 12'd8;
    fast = 1'b0;
    measure(0, l, w, h);
    check("R10 current period low unchanged", l, 5);
    check("R10 current period high unchanged", h, 5);
    measure(0, l, w, h);
    check("R10 next period low", l, 8);
    check("R10 next period high", h, 8);
    // switch to fast duty 16/9 mid-period
    fast = 1'b1; duty = 1'b1; clkc = 12'd1;
    measure(0, l, w, h);
    check("R10 period after mode switch low", l, 8);
    measure(0, l, w, h);
    check("R10 fast duty low", l, 16);
    check("R10 fast duty high", h, 9);

    // R8: disable mid-run keeps everything quiet
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      stretch = k[0];
      check("R8 disabled scl_oe", int'(scl_oe), 0);
      check("R8 disabled strobes", int'(low_start | high_start), 0);
      @(negedge clk);
    end
    stretch = 1'b0;

    // R9: high strobe lasts a single cycle in a long high phase
    fast = 1'b0; clkc = 12'd6; rise = 6'd1;
    restart();
    while (!high_start) @(negedge clk);
    @(negedge clk);
    check("R9 high strobe one cycle", int'(high_start), 0);
    check("R9 line still released", int'(scl_oe), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule